// File: doc/BRIEF.md
# Daughterboard GPIO with Automatic Radio-State Patterns

This block controls 32 bidirectional daughterboard pins split into two sides. Pins 31:16 serve the transmit side and pins 15:0 serve the receive side. A per-pin direction bit decides whether the block drives a pin. For every driven pin, a 2-bit source code picks where the level comes from. The choices are a software-written value, an automatic radio-state pattern, or one of two debug buses.

The automatic controller holds one pattern per side for each of four radio states. It follows the live transmit-active and receive-active inputs, so pins can switch antenna relays or amplifier enables without software involvement.

Configuration uses a simple indexed write port. A readback bus returns the driven level for output pins and a synchronised copy of the pad level for input pins. The pad tristate cells sit outside the block and take `pin_out` and `pin_oe`.

Top module: `gpio_atr_ctrl`

## Requirements
- R1: After reset every register is zero: `pin_oe` is all zeros and `pin_out` is all zeros.
- R2: Writing index 1 loads the direction register; from the next clock `pin_oe` equals the written word, and a 1 bit makes that pin an output.
- R3: An output pin whose source code is 0 drives the matching bit of the software value register (index 0).
- R4: An output pin whose source code is 1 drives the matching bit of the automatic pattern for its side and the current radio state.
- R5: An output pin whose source code is 2 drives the matching bit of `dbg0`. Code 3 drives the matching bit of `dbg1`. Both paths are combinational.
- R6: The radio state is registered from the inputs one clock after they change. `{rx_active,tx_active}` = 00 gives idle (0), 01 gives transmitting (1), 10 gives receiving (2) and 11 gives full duplex (3).
- R7: Pattern slots sit at indices 4 to 11, at index 4 + 2*state + side, where side 0 is the transmit half and side 1 is the receive half. Only bits 15:0 of the write data are stored.
- R8: A pin whose direction bit is 0 has `pin_out` at 0 whatever its source code.
- R9: `rd_io` returns `pin_out` for output pins. For input pins it returns `pin_in` delayed through two flops, so a change appears after the second rising edge.
- R10: The transmit-side select register (index 2) holds the code for pin 16+k in bits 2k+1:2k. The receive-side select register (index 3) holds the code for pin k in bits 2k+1:2k.
- R11: Writes to indices 12 to 15 change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Register index |
| wr_data | input | 32 | Write data |
| tx_active | input | 1 | Radio is transmitting |
| rx_active | input | 1 | Radio is receiving |
| dbg0 | input | 32 | Debug source bus 0 |
| dbg1 | input | 32 | Debug source bus 1 |
| pin_in | input | 32 | Pad input levels |
| pin_out | output | 32 | Pad output levels |
| pin_oe | output | 32 | Pad output enables |
| rd_io | output | 32 | Pin readback |

## Verification
Two functions meet in one cycle. A radio-state change moves the automatic pattern on pins, while other pins in the same word are driven from software or debug sources. Readback of those same pins must also pick between driven values and synchronised pad levels.

The bench sweeps every source code and every radio state under several direction masks. It also runs mixed per-pin select patterns, so all four sources and both readback paths appear in a single output word. Each word is compared bit for bit against an arithmetic model of the register contents.

// File: rtl/gpio_atr_pkg.sv
package gpio_atr_pkg;
    localparam int IDX_W     = 4;
    localparam int ATR_SLOTS = 8;
    localparam int SLOT_W    = $clog2(ATR_SLOTS);

    localparam logic [IDX_W-1:0] IDX_IO       = 4'd0;
    localparam logic [IDX_W-1:0] IDX_DIR      = 4'd1;
    localparam logic [IDX_W-1:0] IDX_SEL_HI   = 4'd2;
    localparam logic [IDX_W-1:0] IDX_SEL_LO   = 4'd3;
    localparam logic [IDX_W-1:0] IDX_ATR_BASE = 4'd4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TX   = 2'd1,
        ST_RX   = 2'd2,
        ST_FDX  = 2'd3
    } radio_state_e;

    typedef enum logic [1:0] {
        SRC_SW   = 2'd0,
        SRC_ATR  = 2'd1,
        SRC_DBG0 = 2'd2,
        SRC_DBG1 = 2'd3
    } pin_src_e;
endpackage

// File: rtl/gpio_atr_regs.sv
module gpio_atr_regs
    import gpio_atr_pkg::*;
#(
    parameter int SIDE_PINS = 16,
    localparam int DATA_W = 2 * SIDE_PINS
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [IDX_W-1:0]                      wr_idx,
    input  logic [DATA_W-1:0]                     wr_data,
    output logic [DATA_W-1:0]                     io_q,
    output logic [DATA_W-1:0]                     dir_q,
    output logic [DATA_W-1:0]                     sel_hi_q,
    output logic [DATA_W-1:0]                     sel_lo_q,
    output logic [ATR_SLOTS-1:0][SIDE_PINS-1:0]   atr_q
);
    typedef struct packed {
        logic [DATA_W-1:0]                   io;
        logic [DATA_W-1:0]                   dir;
        logic [DATA_W-1:0]                   sel_hi;
        logic [DATA_W-1:0]                   sel_lo;
        logic [ATR_SLOTS-1:0][SIDE_PINS-1:0] atr;
    } regs_t;

    regs_t            regs_d, regs_q;
    logic [IDX_W-1:0] slot_off;

    // offsets below the pattern base wrap to values >= ATR_SLOTS
    assign slot_off = wr_idx - IDX_ATR_BASE;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            unique case (wr_idx)
                IDX_IO:     regs_d.io     = wr_data;
                IDX_DIR:    regs_d.dir    = wr_data;
                IDX_SEL_HI: regs_d.sel_hi = wr_data;
                IDX_SEL_LO: regs_d.sel_lo = wr_data;
                default: begin
                    if (slot_off < IDX_W'(ATR_SLOTS))
                        regs_d.atr[slot_off[SLOT_W-1:0]] = wr_data[SIDE_PINS-1:0];
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign io_q     = regs_q.io;
    assign dir_q    = regs_q.dir;
    assign sel_hi_q = regs_q.sel_hi;
    assign sel_lo_q = regs_q.sel_lo;
    assign atr_q    = regs_q.atr;
endmodule

// File: rtl/gpio_atr_state.sv
module gpio_atr_state
    import gpio_atr_pkg::*;
#(
    parameter int SIDE_PINS = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                tx_active,
    input  logic                                rx_active,
    input  logic [ATR_SLOTS-1:0][SIDE_PINS-1:0] atr_tbl,
    output logic [SIDE_PINS-1:0]                atr_hi,
    output logic [SIDE_PINS-1:0]                atr_lo
);
    typedef struct packed {
        radio_state_e st;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d    = state_q;
        state_d.st = radio_state_e'({rx_active, tx_active});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '{st: ST_IDLE};
        else        state_q <= state_d;
    end

    // slot = 2*state + side; side 0 = transmit half, side 1 = receive half
    assign atr_hi = atr_tbl[{state_q.st, 1'b0}];
    assign atr_lo = atr_tbl[{state_q.st, 1'b1}];
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_atr_pkg::*;
#(
    parameter int SIDE_PINS = 16,
    localparam int DATA_W = 2 * SIDE_PINS
) (
    input  logic [DATA_W-1:0]    io,
    input  logic [DATA_W-1:0]    dir,
    input  logic [DATA_W-1:0]    sel_hi,
    input  logic [DATA_W-1:0]    sel_lo,
    input  logic [SIDE_PINS-1:0] atr_hi,
    input  logic [SIDE_PINS-1:0] atr_lo,
    input  logic [DATA_W-1:0]    dbg0,
    input  logic [DATA_W-1:0]    dbg1,
    output logic [DATA_W-1:0]    pin_out,
    output logic [DATA_W-1:0]    pin_oe
);
    assign pin_oe = dir;

    for (genvar p = 0; p < DATA_W; p++) begin : g_pin
        localparam bit IS_HI = (p >= SIDE_PINS);
        localparam int FLD   = IS_HI ? (p - SIDE_PINS) : p;

        logic [1:0] code;
        logic       atr_bit;
        logic       val;

        if (IS_HI) begin : g_hi
            assign code    = sel_hi[2*FLD +: 2];
            assign atr_bit = atr_hi[FLD];
        end else begin : g_lo
            assign code    = sel_lo[2*FLD +: 2];
            assign atr_bit = atr_lo[FLD];
        end

        always_comb begin
            unique case (pin_src_e'(code))
                SRC_SW:   val = io[p];
                SRC_ATR:  val = atr_bit;
                SRC_DBG0: val = dbg0[p];
                default:  val = dbg1[p];
            endcase
            if (!dir[p]) val = 1'b0;
        end

        assign pin_out[p] = val;
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1 = d;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign q = sync_q.s2;
endmodule

// File: rtl/gpio_atr_ctrl.sv
module gpio_atr_ctrl
    import gpio_atr_pkg::*;
#(
    parameter int SIDE_PINS = 16,
    localparam int DATA_W = 2 * SIDE_PINS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tx_active,
    input  logic              rx_active,
    input  logic [DATA_W-1:0] dbg0,
    input  logic [DATA_W-1:0] dbg1,
    input  logic [DATA_W-1:0] pin_in,
    output logic [DATA_W-1:0] pin_out,
    output logic [DATA_W-1:0] pin_oe,
    output logic [DATA_W-1:0] rd_io
);
    logic [DATA_W-1:0]                   io_q, dir_q, sel_hi_q, sel_lo_q;
    logic [ATR_SLOTS-1:0][SIDE_PINS-1:0] atr_q;
    logic [SIDE_PINS-1:0]                atr_hi, atr_lo;
    logic [DATA_W-1:0]                   pin_sync;

    gpio_atr_regs #(.SIDE_PINS(SIDE_PINS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .io_q     (io_q),
        .dir_q    (dir_q),
        .sel_hi_q (sel_hi_q),
        .sel_lo_q (sel_lo_q),
        .atr_q    (atr_q)
    );

    gpio_atr_state #(.SIDE_PINS(SIDE_PINS)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_active (tx_active),
        .rx_active (rx_active),
        .atr_tbl   (atr_q),
        .atr_hi    (atr_hi),
        .atr_lo    (atr_lo)
    );

    gpio_pin_mux #(.SIDE_PINS(SIDE_PINS)) u_mux (
        .io      (io_q),
        .dir     (dir_q),
        .sel_hi  (sel_hi_q),
        .sel_lo  (sel_lo_q),
        .atr_hi  (atr_hi),
        .atr_lo  (atr_lo),
        .dbg0    (dbg0),
        .dbg1    (dbg1),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    gpio_in_sync #(.WIDTH(DATA_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    always_comb begin
        rd_io = (pin_out & pin_oe) | (pin_sync & ~pin_oe);
    end
endmodule

// File: rtl/gpio_atr_ctrl_chk.sv
module gpio_atr_ctrl_chk
    import gpio_atr_pkg::*;
#(
    parameter int SIDE_PINS = 16,
    localparam int DATA_W = 2 * SIDE_PINS
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] pin_in,
    input logic [DATA_W-1:0] pin_out,
    input logic [DATA_W-1:0] pin_oe,
    input logic [DATA_W-1:0] rd_io
);
    logic [1:0] age_q;

    always_ff @(posedge clk) begin
        if (!rst_n)             age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0));

    // R2
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_DIR) |=> (pin_oe == $past(wr_data)));

    // R8
    undriven_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0);

    // R9
    out_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_io ^ pin_out) & pin_oe) == '0);

    // R9
    in_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (((rd_io ^ $past(pin_in, 2)) & ~pin_oe) == '0));
endmodule

bind gpio_atr_ctrl gpio_atr_ctrl_chk #(.SIDE_PINS(SIDE_PINS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .pin_in  (pin_in),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .rd_io   (rd_io)
);

// File: tb/sim_gpio_atr_ctrl.sv
module sim_gpio_atr_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        tx_active = 1'b0;
    logic        rx_active = 1'b0;
    logic [31:0] dbg0 = 32'h0F0F_33CC;
    logic [31:0] dbg1 = 32'hF0E1_D2C3;
    logic [31:0] pin_in = 32'h9669_6996;
    logic [31:0] pin_out, pin_oe, rd_io;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] m_io = '0, m_dir = '0, m_sel_hi = '0, m_sel_lo = '0;
    logic [15:0] m_atr [8];
    logic [1:0]  m_st = 2'd0;

    always #5 clk = ~clk;

    gpio_atr_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .tx_active(tx_active), .rx_active(rx_active), .dbg0(dbg0), .dbg1(dbg1),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .rd_io(rd_io)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] idx, input logic [31:0] data);
        wr_en = 1'b1; wr_idx = idx; wr_data = data;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        case (idx)
            4'd0: m_io = data;
            4'd1: m_dir = data;
            4'd2: m_sel_hi = data;
            4'd3: m_sel_lo = data;
            default: if (idx >= 4'd4 && idx <= 4'd11) m_atr[idx - 4'd4] = data[15:0];
        endcase
    endtask

    task automatic set_state(input logic [1:0] st);
        tx_active = st[0]; rx_active = st[1];
        @(posedge clk); @(negedge clk);
        m_st = st;
    endtask

    function automatic logic [31:0] exp_out();
        logic [31:0] r = '0;
        for (int i = 0; i < 32; i++) begin
            logic [1:0] c;
            logic a;
            if (i >= 16) begin
                c = m_sel_hi[2*(i-16) +: 2];
                a = m_atr[int'(m_st)*2][i-16];
            end else begin
                c = m_sel_lo[2*i +: 2];
                a = m_atr[int'(m_st)*2 + 1][i];
            end
            case (c)
                2'd0: r[i] = m_io[i];
                2'd1: r[i] = a;
                2'd2: r[i] = dbg0[i];
                default: r[i] = dbg1[i];
            endcase
            if (!m_dir[i]) r[i] = 1'b0;
        end
        return r;
    endfunction

    task automatic check_all(input string req);
        logic [31:0] e;
        e = exp_out();
        check(req, pin_out, e);
        check("R2", pin_oe, m_dir);
        check("R8", pin_out & ~pin_oe, 32'h0);
        check("R9", rd_io, (e & m_dir) | (pin_in & ~m_dir));
    endtask

    initial begin
        logic [31:0] dirs [4];
        dirs[0] = 32'hFFFF_FFFF; dirs[1] = 32'h0000_0000;
        dirs[2] = 32'hA5C3_5A3C; dirs[3] = 32'hFFFF_0000;
        for (int k = 0; k < 8; k++) m_atr[k] = '0;

        repeat (3) @(negedge clk);
        // R1: state held in reset
        check("R1", pin_oe, 32'h0);
        check("R1", pin_out, 32'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 R9", rd_io, pin_in);

        // R7: pattern slots, upper bits of data discarded
        for (int k = 0; k < 8; k++)
            wr(4'(4 + k), {16'hDEAD, 16'(16'h1357 * (k + 1)) ^ 16'h3C5A});
        wr(4'd0, 32'h5A5A_C3C3);

        // R3 R4 R5 R6: every source code in every radio state
        for (int d = 0; d < 4; d++) begin
            wr(4'd1, dirs[d]);
            for (int c = 0; c < 4; c++) begin
                wr(4'd2, {16{2'(c)}});
                wr(4'd3, {16{2'(c)}});
                for (int s = 0; s < 4; s++) begin
                    set_state(2'(s));
                    case (c)
                        0: check_all("R3");
                        1: check_all("R4 R6 R7");
                        default: check_all("R5");
                    endcase
                end
            end
        end

        // R10: per-pin codes mixed within each select word
        wr(4'd1, 32'hFFFF_FFFF);
        wr(4'd2, 32'h1B1B_1B1B);
        wr(4'd3, 32'hE4E4_E4E4);
        for (int s = 0; s < 4; s++) begin
            set_state(2'(s));
            check_all("R10");
        end
        wr(4'd1, 32'h3CC3_A55A);
        for (int s = 3; s >= 0; s--) begin
            set_state(2'(s));
            check_all("R10 R6");
        end

        // R5: debug paths are combinational
        wr(4'd2, 32'hAAAA_FFFF);
        wr(4'd3, 32'hFFFF_AAAA);
        dbg0 = 32'h1234_8765; dbg1 = 32'hFEDC_0123;
        #1;
        check_all("R5");

        // R11: unused indices leave everything untouched
        for (int k = 12; k < 16; k++) wr(4'(k), 32'hFFFF_FFFF);
        for (int s = 0; s < 4; s++) begin
            set_state(2'(s));
            check_all("R11");
        end

        // R9: input pin readback goes through two flops
        wr(4'd1, 32'hFFFF_0000);
        pin_in = 32'h0000_5AA5 ^ pin_in;
        @(posedge clk); @(negedge clk);
        check("R9", rd_io[15:0], (pin_in[15:0] ^ 16'h5AA5));
        @(posedge clk); @(negedge clk);
        check("R9", rd_io[15:0], pin_in[15:0]);
        check_all("R9");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule